// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of an SPI master from a faster module clock. A mode input selects one of two division laws. The linear law divides by 2*(N+1), where N is an 8-bit field. The power-of-two law divides by 2^N, where N is a 4-bit exponent. An exponent of zero in power-of-two mode forwards the module clock unchanged. Every even ratio gives a 50% duty cycle. The block also drives two strobes, one for each rising edge and one for each falling edge of the serial clock. Each strobe is asserted in the module-clock cycle before the edge it announces, so shift logic can prepare data one cycle early.

The controller is a small state machine with four states:
- `S_IDLE`: enable is low, the serial clock is low and the counter is zero.
- `S_LOW` and `S_HIGH`: the two half-periods of a divided clock.
- `S_BYP`: the forwarding state.

The transitions are:
- **start**: `S_IDLE` to `S_LOW`, or to `S_BYP`, on the first enabled cycle.
- **rise**: `S_LOW` to `S_HIGH` at the terminal count.
- **fall**: `S_HIGH` to `S_LOW` at the terminal count.
- **to-bypass**: `S_LOW` to `S_BYP` when the newly sampled setting is divide-by-1.
- **leave-bypass**: `S_BYP` to `S_LOW` when the setting is no longer divide-by-1.
- **stop**: from any state to `S_IDLE` when enable falls.

The mode and both fields are loaded into an internal copy only at the start and at each rise transition. A half-period that is already running is therefore never shortened or stretched.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `lin_mode`=1 and `lin_div`=N, the serial clock is high for N+1 module cycles and low for N+1 module cycles, so the ratio is 2*(N+1).
- R2: With `lin_mode`=0 and `pow_exp`=E with E≥1, the high and low phases each last 2^(E-1) module cycles, so the ratio is 2^E and not 2^(E+1).
- R3: `lin_mode`=1 selects the linear law and `lin_mode`=0 selects the power-of-two law.
- R4: With `lin_mode`=0 and `pow_exp`=0, the block is in forwarding mode. One cycle after enable is sampled high, `sclk` equals the module clock, and `rise_stb` and `fall_stb` are both held high.
- R5: Outside forwarding mode, `rise_stb` is high for exactly one module cycle per period: the cycle whose closing edge drives `sclk` high. `fall_stb` behaves the same way for the falling edge.
- R6: A change to `lin_mode`, `lin_div` or `pow_exp` takes effect only at the next rising edge of `sclk`. The current high phase and the following low phase keep their old length.
- R7: While `en` is low, `sclk` and both strobes are low from the next cycle on. After `en` returns high, the first rising edge of `sclk` comes H+1 cycles later, where H is the half-period length.
- R8: After synchronous reset, `sclk`, `rise_stb` and `fall_stb` are low.
- R9: A linear field of 2 gives a divide-by-6. For example, a 214,285 Hz module clock yields about 35,714 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces the idle state |
| lin_mode | input | 1 | 1 = linear law, 0 = power-of-two law |
| lin_div | input | 8 | Linear field N, ratio 2*(N+1) |
| pow_exp | input | 4 | Exponent E, ratio 2^E (0 = forward) |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | High in the cycle before `sclk` rises |
| fall_stb | output | 1 | High in the cycle before `sclk` falls |

## Verification
The linear field is swept over all 256 values and the exponent over 1 to 12. Each setting is measured for:
- start-up latency;
- high length and low length;
- strobe position and count.

Together these separate an off-by-one in either law and a spurious extra factor of two in the power law. The example ratio of 6 is checked on its own. Forwarding mode is sampled at both clock levels. Reprogramming during a high phase is tested, once within the linear law and once across a mode switch. This shows that old phase lengths persist until the next rise. Dropping enable mid-phase, followed by a restart, shows that the counter was cleared.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_BYP  = 2'd3
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_term.sv
// Converts the programmed law and field into a terminal count (half-period - 1).
module sdiv_term #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 14
) (
    input  logic             lin_mode,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] pow_exp,
    output logic [CNT_W-1:0] term,
    output logic             byp
);
    logic [CNT_W:0] pow_half;

    always_comb begin
        pow_half = '0;
        if (pow_exp != '0) begin
            pow_half = ((CNT_W+1)'(1) << (pow_exp - EXP_W'(1))) - (CNT_W+1)'(1);
        end
        byp = !lin_mode && (pow_exp == '0);
        if (lin_mode) begin
            term = CNT_W'(lin_div);
        end else begin
            term = pow_half[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/sdiv_fsm.sv
// Phase state machine: counts half-periods, loads settings only at period boundaries.
module sdiv_fsm
    import sdiv_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cfg_term,
    input  logic             cfg_byp,
    output logic             sclk_q,
    output logic             in_byp,
    output logic             rise_stb,
    output logic             fall_stb
);
    sdiv_state_e      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] term_q;
    logic             load;
    logic             at_end;

    assign at_end = (cnt == term_q);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        if (!en) begin
            st_n  = S_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    load  = 1'b1;
                    cnt_n = '0;
                    st_n  = cfg_byp ? S_BYP : S_LOW;
                end
                S_LOW: begin
                    if (at_end) begin
                        load  = 1'b1;
                        cnt_n = '0;
                        st_n  = cfg_byp ? S_BYP : S_HIGH;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                S_HIGH: begin
                    if (at_end) begin
                        cnt_n = '0;
                        st_n  = S_LOW;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                S_BYP: begin
                    load  = 1'b1;
                    cnt_n = '0;
                    st_n  = cfg_byp ? S_BYP : S_LOW;
                end
                default: begin
                    st_n  = S_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            term_q <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (load) term_q <= cfg_term;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= (st_n == S_HIGH);
    end

    always_comb begin
        in_byp   = (st == S_BYP);
        rise_stb = en && (in_byp || (st == S_LOW  && at_end));
        fall_stb = en && (in_byp || (st == S_HIGH && at_end));
    end

    AST_IDLE_LOW:    assert property (@(posedge clk) disable iff (rst) !en |=> !sclk_q && !rise_stb);        // R7
    AST_RISE_NEXT:   assert property (@(posedge clk) disable iff (rst) (rise_stb && !in_byp && !cfg_byp) |=> sclk_q); // R5
    AST_FALL_NEXT:   assert property (@(posedge clk) disable iff (rst) (fall_stb && !in_byp) |=> !sclk_q);   // R5
    AST_STB_EXCL:    assert property (@(posedge clk) disable iff (rst) !in_byp |-> !(rise_stb && fall_stb)); // R5
    AST_HOLD_CFG:    assert property (@(posedge clk) disable iff (rst) (st == S_HIGH) |=> $stable(term_q));  // R6
    AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (rst) cnt <= term_q);                       // R1
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             lin_mode,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] pow_exp,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int MAX_SH = (1 << EXP_W) - 2;
    localparam int CNT_W  = (MAX_SH > LIN_W) ? MAX_SH : LIN_W;

    logic [CNT_W-1:0] cfg_term;
    logic             cfg_byp;
    logic             sclk_q;
    logic             in_byp;

    sdiv_term #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_term (
        .lin_mode (lin_mode),
        .lin_div  (lin_div),
        .pow_exp  (pow_exp),
        .term     (cfg_term),
        .byp      (cfg_byp)
    );

    sdiv_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_term (cfg_term),
        .cfg_byp  (cfg_byp),
        .sclk_q   (sclk_q),
        .in_byp   (in_byp),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    assign sclk = in_byp ? clk : sclk_q;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !sclk_q); // R8
endmodule

// File: tb/spi_sclk_divider_test.sv
`timescale 1ns/1ps
module spi_sclk_divider_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       lin_mode = 1'b1;
    logic [7:0] lin_div = 8'd0;
    logic [3:0] pow_exp = 4'd0;
    logic       sclk, rise_stb, fall_stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    spi_sclk_divider uut (
        .clk(clk), .rst(rst), .en(en), .lin_mode(lin_mode),
        .lin_div(lin_div), .pow_exp(pow_exp),
        .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Counts samples while sclk stays at lvl; leaves at the first sample of the other level.
    task automatic phase(input logic lvl, output int n, output int nr, output int nf,
                         output logic lr, output logic lf);
        n = 0; nr = 0; nf = 0; lr = 0; lf = 0;
        while (sclk == lvl && n < 70000) begin
            n++;
            nr += int'(rise_stb);
            nf += int'(fall_stb);
            lr = rise_stb;
            lf = fall_stb;
            step();
        end
    endtask

    // Returns samples from enable to first high sample; checks strobe before the rise.
    task automatic start(output int lat);
        logic pr;
        lat = 0;
        en = 1'b1;
        pr = rise_stb;
        while (sclk == 1'b0 && lat < 70000) begin
            pr = rise_stb;
            step();
            lat++;
        end
        check(pr == 1'b1, "R5 rise strobe before first rise", int'(pr), 1);
    endtask

    task automatic run_cfg(input logic m, input logic [7:0] nl, input logic [3:0] e,
                           input int h, input string tag);
        int lat, n, nr, nf;
        logic lr, lf;
        en = 1'b0; lin_mode = m; lin_div = nl; pow_exp = e;
        step(); step();
        start(lat);
        check(lat == h + 1, {tag, " R7 start latency"}, lat, h + 1);
        phase(1'b1, n, nr, nf, lr, lf);
        check(n == h && lf && nf == 1 && nr == 0, {tag, " high phase"}, n, h);
        phase(1'b0, n, nr, nf, lr, lf);
        check(n == h && lr && nr == 1 && nf == 0, {tag, " low phase R5"}, n, h);
    endtask

    initial begin
        int n, nr, nf, lat;
        logic lr, lf;
        repeat (3) step();
        check(sclk == 0 && rise_stb == 0 && fall_stb == 0, "R8 reset quiet", int'(sclk), 0);
        rst = 1'b0;
        step();

        // R1 / R3: linear law, every field value
        for (int i = 0; i < 256; i++) run_cfg(1'b1, 8'(i), 4'd5, i + 1, "R1 R3 linear");
        // R2 / R3: power law, exponents 1..12
        for (int e = 1; e <= 12; e++) run_cfg(1'b0, 8'd9, 4'(e), 1 << (e - 1), "R2 R3 power");
        // R9: field 2 gives divide-by-6
        run_cfg(1'b1, 8'd2, 4'd0, 3, "R9 divide by 6");

        // R4: forwarding mode
        en = 1'b0; lin_mode = 1'b0; pow_exp = 4'd0;
        step(); step();
        en = 1'b1;
        step();
        check(sclk == 1'b1, "R4 forwarded high level", int'(sclk), 1);
        check(rise_stb && fall_stb, "R4 strobes held", int'(rise_stb) + int'(fall_stb), 2);
        @(negedge clk); #1;
        check(sclk == 1'b0, "R4 forwarded low level", int'(sclk), 0);

        // R6: reprogram linear field mid high phase (N=3 -> 0)
        en = 1'b0; lin_mode = 1'b1; lin_div = 8'd3;
        step(); step();
        start(lat);
        step();
        lin_div = 8'd0;
        phase(1'b1, n, nr, nf, lr, lf);
        check(n == 3, "R6 high keeps old length", n + 1, 4);
        phase(1'b0, n, nr, nf, lr, lf);
        check(n == 4, "R6 low keeps old length", n, 4);
        phase(1'b1, n, nr, nf, lr, lf);
        check(n == 1, "R6 new high length", n, 1);
        phase(1'b0, n, nr, nf, lr, lf);
        check(n == 1, "R6 new low length", n, 1);

        // R6 / R3: mode switch mid high phase (linear N=1 -> power E=3)
        en = 1'b0; lin_mode = 1'b1; lin_div = 8'd1;
        step(); step();
        start(lat);
        lin_mode = 1'b0; pow_exp = 4'd3;
        phase(1'b1, n, nr, nf, lr, lf);
        check(n == 2, "R6 R3 high old law", n, 2);
        phase(1'b0, n, nr, nf, lr, lf);
        check(n == 2, "R6 R3 low old law", n, 2);
        phase(1'b1, n, nr, nf, lr, lf);
        check(n == 4, "R6 R3 high new law", n, 4);
        phase(1'b0, n, nr, nf, lr, lf);
        check(n == 4, "R6 R3 low new law", n, 4);

        // R7: drop enable mid high phase, then restart
        en = 1'b0; lin_mode = 1'b1; lin_div = 8'd5;
        step(); step();
        start(lat);
        step();
        en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step();
            check(!sclk && !rise_stb && !fall_stb, "R7 idle while disabled",
                  int'(sclk) + int'(rise_stb) + int'(fall_stb), 0);
        end
        lin_div = 8'd2;
        start(lat);
        check(lat == 4, "R7 restart latency after stop", lat, 4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule